// File: doc/BRIEF.md
# Inter-processor and timer interrupt controller

This block holds two sets of per-CPU pending flags for up to four processors: one for inter-processor interrupts (IPIs) and one for periodic timer interrupts. Software reaches it through a small register port with four register selects. A single write to the control register can raise IPIs, drop IPIs and acknowledge timer interrupts at once, each through its own 4-bit CPU mask. Three narrower registers read back the IPI and timer masks, clear them, or raise IPIs. A one-cycle `tick` input from the periodic timer source marks a timer interrupt pending on every CPU.

Each pending flag drives one interrupt output directly, so a change is seen at the pins one clock after the write or tick that caused it. Two one-cycle flags report trouble. `errFlag` marks an access the block does not support: a control write with no active field, or a mask write with an all-zero mask. `warnFlag` marks a redundant IPI operation, meaning a post to a CPU that already has an IPI pending or a clear of one that has none.

Top module: `ipi_timer_intc`

## Requirements
- R1: A synchronous reset clears every IPI and timer pending bit, both interrupt outputs, `errFlag`, `warnFlag` and `rdData`.
- R2: A write to select 0 (control) takes bits 15:12 as a mask of IPIs to post, bits 11:8 as a mask of IPIs to clear and bits 7:4 as a mask of timer interrupts to clear, all acting in the same write. Mask bit i addresses CPU i. When the same CPU is posted and cleared in one write, the clear takes effect last and the IPI ends not pending.
- R3: A control write with only bit 28 set is accepted: it changes no pending bit and raises neither `errFlag` nor `warnFlag`.
- R4: A control write in which bits 15:4 and bit 28 are all zero pulses `errFlag` for one cycle and leaves all pending bits unchanged.
- R5: Writes to select 1 (clear IPIs), select 2 (clear timer) and select 3 (post IPIs) use bits 3:0 as the CPU mask. An all-zero mask pulses `errFlag` and changes nothing.
- R6: Posting an IPI to a CPU whose IPI is already pending, or clearing an IPI on a CPU with none pending, pulses `warnFlag` for one cycle. That CPU's IPI bit keeps its value.
- R7: A `tick` cycle sets the timer pending bit of every CPU. If the same cycle also clears a timer bit, the tick wins.
- R8: A timer clear drops only CPUs whose timer bit is pending. It never pulses `warnFlag`, and no timer bit rises without a tick.
- R9: A read of select 0 returns the IPI mask in bits 11:8, the timer mask in bits 7:4 and `cpuId` in bits 1:0, with all other bits zero. `rdData` is loaded at the clock edge that samples `rdEn` and reflects the state from before any write in that same cycle.
- R10: A read of select 1 returns the IPI mask in bits 3:0, a read of select 2 returns the timer mask in bits 3:0, and a read of select 3 returns zero.
- R11: `ipiIrq` and `tmrIrq` are registered copies of the pending bits. They change only on the edge after a write or a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Periodic timer pulse, one cycle per period |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| regAddr | input | 2 | Register select: 0 control, 1 IPI status/clear, 2 timer status/clear, 3 IPI post |
| wrData | input | 32 | Write data |
| cpuId | input | 2 | ID of the CPU that issues the access |
| rdData | output | 32 | Read data, registered |
| ipiIrq | output | NCPU | Per-CPU IPI interrupt |
| tmrIrq | output | NCPU | Per-CPU timer interrupt |
| errFlag | output | 1 | One-cycle pulse on an unsupported access |
| warnFlag | output | 1 | One-cycle pulse on a redundant IPI post or clear |

## Verification
The pending flags drive the interrupt pins directly. A flag that is set or dropped wrongly therefore shows on `ipiIrq` or `tmrIrq` on the very next edge, with no further stimulus needed. A wrong decode of a write field shows up as a mask mismatch in the cycle after that write. A mis-ordered post/clear or tick/clear shows as a single wrong bit in the same cycle. A broken read path shows one edge after the read, since each read returns the pending state against expected masks and the CPU ID.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int CPU_MAX  = 4;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 2;
  localparam int ID_W     = 2;
  // field positions decoded from the control register
  localparam int POST_LSB = 12;
  localparam int CLR_LSB  = 8;
  localparam int TACK_LSB = 4;
  localparam int NXM_BIT  = 28;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL     = 2'd0,
    REG_IPI_STAT = 2'd1,
    REG_TMR_STAT = 2'd2,
    REG_IPI_POST = 2'd3
  } regSel_e;

  typedef struct packed {
    logic [CPU_MAX-1:0] ipiPost;
    logic [CPU_MAX-1:0] ipiClr;
    logic [CPU_MAX-1:0] tmrClr;
    logic               badAccess;
    logic               rdStb;
    regSel_e            rdSel;
  } strobe_t;
endpackage

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
#(
  parameter int NCPU = 4
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] wrData,
  output strobe_t           stb
);
  localparam logic [CPU_MAX-1:0] CPU_MASK = CPU_MAX'((1 << NCPU) - 1);

  logic [CPU_MAX-1:0] postField;
  logic [CPU_MAX-1:0] clrField;
  logic [CPU_MAX-1:0] tackField;
  logic [CPU_MAX-1:0] lowField;
  logic               nxmAck;

  assign postField = wrData[POST_LSB +: CPU_MAX] & CPU_MASK;
  assign clrField  = wrData[CLR_LSB  +: CPU_MAX] & CPU_MASK;
  assign tackField = wrData[TACK_LSB +: CPU_MAX] & CPU_MASK;
  assign lowField  = wrData[CPU_MAX-1:0]         & CPU_MASK;
  assign nxmAck    = wrData[NXM_BIT];

  always_comb begin
    stb       = '0;
    stb.rdStb = rdEn;
    stb.rdSel = regSel_e'(regAddr);
    if (wrEn) begin
      unique case (regSel_e'(regAddr))
        REG_CTRL: begin
          stb.ipiPost   = postField;
          stb.ipiClr    = clrField;
          stb.tmrClr    = tackField;
          stb.badAccess = ~(|postField | |clrField | |tackField | nxmAck);
        end
        REG_IPI_STAT: begin
          stb.ipiClr    = lowField;
          stb.badAccess = ~|lowField;
        end
        REG_TMR_STAT: begin
          stb.tmrClr    = lowField;
          stb.badAccess = ~|lowField;
        end
        REG_IPI_POST: begin
          stb.ipiPost   = lowField;
          stb.badAccess = ~|lowField;
        end
        default: stb.badAccess = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/intc_dp.sv
module intc_dp
  import intc_pkg::*;
#(
  parameter int NCPU = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  strobe_t           stb,
  input  logic [ID_W-1:0]   cpuId,
  output logic [NCPU-1:0]   ipiPend,
  output logic [NCPU-1:0]   tmrPend,
  output logic [DATA_W-1:0] rdData,
  output logic              errFlag,
  output logic              warnFlag
);
  logic [NCPU-1:0]   warnVec;
  logic [DATA_W-1:0] rdNext;

  for (genvar i = 0; i < NCPU; i++) begin : g_cpu
    // a clear of a CPU posted in the same write finds it pending
    assign warnVec[i] = (stb.ipiPost[i] & ipiPend[i]) |
                        (stb.ipiClr[i] & ~ipiPend[i] & ~stb.ipiPost[i]);

    always_ff @(posedge clk) begin
      if (rst) begin
        ipiPend[i] <= 1'b0;
        tmrPend[i] <= 1'b0;
      end else begin
        ipiPend[i] <= (ipiPend[i] | stb.ipiPost[i]) & ~stb.ipiClr[i];
        tmrPend[i] <= (tmrPend[i] & ~stb.tmrClr[i]) | tick;
      end
    end
  end

  always_comb begin
    rdNext = '0;
    unique case (stb.rdSel)
      REG_CTRL: begin
        rdNext[CLR_LSB  +: NCPU] = ipiPend;
        rdNext[TACK_LSB +: NCPU] = tmrPend;
        rdNext[ID_W-1:0]         = cpuId;
      end
      REG_IPI_STAT: rdNext[NCPU-1:0] = ipiPend;
      REG_TMR_STAT: rdNext[NCPU-1:0] = tmrPend;
      default:      rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdData   <= '0;
      errFlag  <= 1'b0;
      warnFlag <= 1'b0;
    end else begin
      if (stb.rdStb) rdData <= rdNext;
      errFlag  <= stb.badAccess;
      warnFlag <= |warnVec;
    end
  end
endmodule

// File: rtl/ipi_timer_intc.sv
module ipi_timer_intc
  import intc_pkg::*;
#(
  parameter int NCPU = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ID_W-1:0]   cpuId,
  output logic [DATA_W-1:0] rdData,
  output logic [NCPU-1:0]   ipiIrq,
  output logic [NCPU-1:0]   tmrIrq,
  output logic              errFlag,
  output logic              warnFlag
);
  strobe_t stb;

  intc_ctrl #(.NCPU(NCPU)) u_ctrl (
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .regAddr (regAddr),
    .wrData  (wrData),
    .stb     (stb)
  );

  intc_dp #(.NCPU(NCPU)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .stb      (stb),
    .cpuId    (cpuId),
    .ipiPend  (ipiIrq),
    .tmrPend  (tmrIrq),
    .rdData   (rdData),
    .errFlag  (errFlag),
    .warnFlag (warnFlag)
  );
endmodule

// File: rtl/intc_chk.sv
module intc_chk
  import intc_pkg::*;
#(
  parameter int NCPU = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              wrEn,
  input logic              rdEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] wrData,
  input logic [ID_W-1:0]   cpuId,
  input logic [DATA_W-1:0] rdData,
  input logic [NCPU-1:0]   ipiIrq,
  input logic [NCPU-1:0]   tmrIrq,
  input logic              errFlag,
  input logic              warnFlag
);
  // R4
  empty_ctrl_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && regAddr == 2'd0 && wrData[15:4] == '0 && !wrData[NXM_BIT] && !tick)
    |=> (errFlag && $stable(ipiIrq) && $stable(tmrIrq)));

  // R5
  zero_post_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && regAddr == 2'd3 && wrData[3:0] == '0) |=> (errFlag && $stable(ipiIrq)));

  // R7
  tick_sets_all_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> (&tmrIrq));

  // R8
  no_tmr_rise_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ((tmrIrq & ~$past(tmrIrq)) == '0));

  // R11
  ipi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wrEn |=> $stable(ipiIrq));

  // R6
  warn_cause_chk: assert property (@(posedge clk) disable iff (rst)
    warnFlag |-> $past(wrEn));
endmodule

bind ipi_timer_intc intc_chk #(.NCPU(NCPU)) u_chk (.*);

// File: tb/sim_ipi_timer_intc.sv
module sim_ipi_timer_intc;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [31:0] wrData = '0;
  logic [1:0]  cpuId = '0;
  logic [31:0] rdData;
  logic [3:0]  ipiIrq;
  logic [3:0]  tmrIrq;
  logic        errFlag;
  logic        warnFlag;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ipi_timer_intc #(.NCPU(4)) u0 (.*);

  // {addr, data, expIpi, expTmr, expErr, expWarn}; starts with ipi=0, tmr=F
  localparam int NVEC = 13;
  localparam logic [43:0] VEC [NVEC] = '{
    {2'd0, 32'h0000_3000, 4'h3, 4'hF, 1'b0, 1'b0},  // R2 post cpu0,1
    {2'd0, 32'h0000_1000, 4'h3, 4'hF, 1'b0, 1'b1},  // R6 repost cpu0
    {2'd3, 32'h0000_000C, 4'hF, 4'hF, 1'b0, 1'b0},  // R5 post reg
    {2'd0, 32'h0000_0510, 4'hA, 4'hE, 1'b0, 1'b0},  // R2 clear ipi 0,2 and tmr 0
    {2'd1, 32'h0000_0002, 4'h8, 4'hE, 1'b0, 1'b0},  // R5 clear reg
    {2'd1, 32'h0000_0002, 4'h8, 4'hE, 1'b0, 1'b1},  // R6 clear idle cpu1
    {2'd2, 32'h0000_0006, 4'h8, 4'h8, 1'b0, 1'b0},  // R8 timer clear reg
    {2'd0, 32'h1000_0000, 4'h8, 4'h8, 1'b0, 1'b0},  // R3 nxm only
    {2'd0, 32'h0000_0000, 4'h8, 4'h8, 1'b1, 1'b0},  // R4 empty ctrl
    {2'd3, 32'h0000_0000, 4'h8, 4'h8, 1'b1, 1'b0},  // R5 zero mask
    {2'd0, 32'h0000_F0F0, 4'hF, 4'h0, 1'b0, 1'b1},  // R2 R6 post all, cpu3 already
    {2'd0, 32'h0000_1100, 4'hE, 4'h0, 1'b0, 1'b1},  // R2 post+clear cpu0
    {2'd2, 32'h0000_0001, 4'hE, 4'h0, 1'b0, 1'b0}   // R8 clear idle timer, no warn
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [1:0] a, input logic [31:0] d, input logic tk);
    @(negedge clk);
    wrEn = 1'b1; regAddr = a; wrData = d; tick = tk;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0; tick = 1'b0;
  endtask

  task automatic doRead(input logic [1:0] a, input logic [1:0] id);
    @(negedge clk);
    rdEn = 1'b1; regAddr = a; cpuId = id;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic doTick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 ipi", {28'd0, ipiIrq}, 32'h0);
    chk("R1 tmr", {28'd0, tmrIrq}, 32'h0);
    chk("R1 flags", {30'd0, errFlag, warnFlag}, 32'h0);
    chk("R1 rdData", rdData, 32'h0);

    doTick();
    // R7 tick sets all
    chk("R7 tick", {28'd0, tmrIrq}, 32'hF);

    for (int v = 0; v < NVEC; v++) begin
      logic [43:0] e;
      e = VEC[v];
      doWrite(e[43:42], e[41:10], 1'b0);
      chk($sformatf("R2 R5 R6 vec%0d ipi", v), {28'd0, ipiIrq}, {28'd0, e[9:6]});
      chk($sformatf("R8 R3 vec%0d tmr", v), {28'd0, tmrIrq}, {28'd0, e[5:2]});
      chk($sformatf("R4 R5 vec%0d err", v), {31'd0, errFlag}, {31'd0, e[1]});
      chk($sformatf("R6 vec%0d warn", v), {31'd0, warnFlag}, {31'd0, e[0]});
    end

    // R11 flags are single pulses and outputs hold without writes
    @(negedge clk);
    chk("R11 hold ipi", {28'd0, ipiIrq}, 32'hE);
    chk("R4 err pulse ends", {31'd0, errFlag}, 32'h0);

    // R9 control read with id 2: ipi E, tmr 0
    doRead(2'd0, 2'd2);
    chk("R9 ctrl read", rdData, 32'h0000_0E02);

    // R7 tick together with timer clear of cpu1: tick wins
    doWrite(2'd2, 32'h2, 1'b1);
    chk("R7 tick beats clear", {28'd0, tmrIrq}, 32'hF);

    // R10 status reads
    doRead(2'd1, 2'd1);
    chk("R10 ipi status", rdData, 32'h0000_000E);
    doRead(2'd2, 2'd1);
    chk("R10 tmr status", rdData, 32'h0000_000F);
    doRead(2'd3, 2'd1);
    chk("R10 post reg reads zero", rdData, 32'h0);
    doRead(2'd0, 2'd3);
    chk("R9 ctrl read id3", rdData, 32'h0000_0EF3);

    // R9 read in the same cycle as a write returns old state
    @(negedge clk);
    rdEn = 1'b1; wrEn = 1'b1; regAddr = 2'd1; wrData = 32'h4;
    @(negedge clk);
    rdEn = 1'b0; wrEn = 1'b0; wrData = '0;
    chk("R9 read before write", rdData, 32'h0000_000E);
    chk("R11 ipi after clear", {28'd0, ipiIrq}, 32'hA);

    // R1 reset mid-run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 reset ipi", {28'd0, ipiIrq}, 32'h0);
    chk("R1 reset tmr", {28'd0, tmrIrq}, 32'h0);
    chk("R1 reset rdData", rdData, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule